// File: doc/BRIEF.md
# System-Management Interrupt Dispatcher with Firmware Feature Handshake

This block watches writes to the power-management command port and decides what each command does. Two reserved command codes turn ACPI mode on and off. They produce a one-cycle pulse on a dedicated output and never raise a system-management interrupt (SMI). Any other code raises an SMI, provided that the command-port enable bit of the SMI enable register is set. The SMI goes only to the processor that issued the command. If firmware has negotiated the broadcast feature, it goes to every processor instead.

Negotiation is a one-shot handshake over a byte-wide register port. The host-supported mask is fixed by a parameter and can only be read. Firmware writes a 64-bit requested mask and then writes the confirm register. If the request is a subset of the host mask, it is latched as the negotiated mask and the confirm flag becomes 1. From then on the negotiated mask is frozen until reset. A sticky lock bit freezes itself and the global SMI enable bit in the same way.

Top module: `smi_dispatch`

## Requirements
- R1: A command write of ACPI_ON_CODE (default 0xE1) raises `acpi_on` for exactly the cycle after the write, and `smi_req` stays all-zero.
- R2: A command write of ACPI_OFF_CODE (default 0x1E) raises `acpi_off` for exactly the cycle after the write, and `smi_req` stays all-zero.
- R3: Any other command value raises an SMI only when bit 5 of the SMI enable register (address 0x11) is 1. When that bit is 0, `smi_req` stays all-zero.
- R4: An SMI is a one-cycle pulse in the cycle after the command write. It goes to every bit of `smi_req` when bit 0 (broadcast) of the negotiated mask is 1. Otherwise only bit `cmd_cpu` is set.
- R5: A write of any value to the confirm register (0x10) while the flag is 0 copies the requested mask to the negotiated mask and sets the flag if the requested mask has no bit outside the host mask. The flag reads as bit 0 of 0x10.
- R6: A confirm write with a requested bit outside the host mask leaves the flag at 0 and the negotiated mask unchanged.
- R7: While the flag is 1, confirm writes have no effect, and the negotiated mask keeps its value even when the requested mask changes.
- R8: After reset the requested mask, the flag, the negotiated mask, the SMI enable register and the lock all read 0. The host mask reads HOST_FEAT (default 0x1, broadcast set).
- R9: Writing 1 to bit 0 of the lock register (0x12) sets the lock. From then until reset, the lock and bit 0 of 0x11 ignore writes. Bits 7:1 of 0x11 stay writable.
- R10: The feature words are byte-addressed little-endian. Byte k of the host mask is at 0x00+k, of the requested mask at 0x08+k, and of the negotiated mask at 0x18+k. The host and negotiated bytes ignore writes. Addresses 0x13 to 0x17 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_data | input | 8 | Command value |
| cmd_cpu | input | CPU_IDW | Index of the processor issuing the command |
| reg_wr | input | 1 | Register-port byte write strobe |
| reg_addr | input | 5 | Register-port byte address |
| reg_wdata | input | 8 | Register-port write data |
| reg_rdata | output | 8 | Register-port read data, combinational on address |
| smi_req | output | NUM_CPU | Per-processor SMI request pulses |
| acpi_on | output | 1 | ACPI-enable pulse |
| acpi_off | output | 1 | ACPI-disable pulse |

## Verification
Every command result (the SMI pulses and both ACPI pulses) is registered. It is due in the single cycle that follows the write edge and is gone one cycle later. The bench raises the strobe at a falling edge, checks the outputs at the next falling edge, and then checks again that they have returned to zero. Register writes take effect at the same edge. Because read data is combinational, a read issued at the following falling edge already shows the new state. A bench model covers random command and register traffic mixed with directed handshake and lock sequences.

// File: rtl/smi_dispatch.sv
module smi_dispatch #(
  parameter int          NUM_CPU       = 4,
  parameter logic [7:0]  ACPI_ON_CODE  = 8'hE1,
  parameter logic [7:0]  ACPI_OFF_CODE = 8'h1E,
  parameter logic [63:0] HOST_FEAT     = 64'h1,
  parameter int          BCAST_BIT     = 0,
  parameter int          APM_EN_BIT    = 5,
  localparam int         CPU_IDW       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [7:0]         cmd_data,
  input  logic [CPU_IDW-1:0] cmd_cpu,
  input  logic               reg_wr,
  input  logic [4:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic [NUM_CPU-1:0] smi_req,
  output logic               acpi_on,
  output logic               acpi_off
);
  localparam logic [4:0] A_OK   = 5'h10;
  localparam logic [4:0] A_EN   = 5'h11;
  localparam logic [4:0] A_LOCK = 5'h12;

  logic [63:0] req_q, nego_q;
  logic        ok_q, lock_q;
  logic [7:0]  en_q;

  wire [5:0] bsel       = {reg_addr[2:0], 3'b000};
  wire       is_acpi    = (cmd_data == ACPI_ON_CODE) || (cmd_data == ACPI_OFF_CODE);
  wire       fire       = cmd_wr && !is_acpi && en_q[APM_EN_BIT];
  wire       subset     = (req_q & ~HOST_FEAT) == 64'h0;
  wire [NUM_CPU-1:0] one_cpu = NUM_CPU'(1) << cmd_cpu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      nego_q   <= '0;
      ok_q     <= 1'b0;
      lock_q   <= 1'b0;
      en_q     <= '0;
      smi_req  <= '0;
      acpi_on  <= 1'b0;
      acpi_off <= 1'b0;
    end else begin
      acpi_on  <= cmd_wr && (cmd_data == ACPI_ON_CODE);
      acpi_off <= cmd_wr && (cmd_data == ACPI_OFF_CODE);
      smi_req  <= fire ? (nego_q[BCAST_BIT] ? {NUM_CPU{1'b1}} : one_cpu) : '0;
      if (reg_wr) begin
        if (reg_addr[4:3] == 2'b01)
          req_q[bsel +: 8] <= reg_wdata;
        if (reg_addr == A_OK && !ok_q && subset) begin
          nego_q <= req_q;
          ok_q   <= 1'b1;
        end
        if (reg_addr == A_EN)
          en_q <= lock_q ? {reg_wdata[7:1], en_q[0]} : reg_wdata;
        if (reg_addr == A_LOCK && !lock_q)
          lock_q <= reg_wdata[0];
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr[4:3])
      2'b00: reg_rdata = HOST_FEAT[bsel +: 8];
      2'b01: reg_rdata = req_q[bsel +: 8];
      2'b11: reg_rdata = nego_q[bsel +: 8];
      default: begin
        if (reg_addr == A_OK)   reg_rdata = {7'b0, ok_q};
        if (reg_addr == A_EN)   reg_rdata = en_q;
        if (reg_addr == A_LOCK) reg_rdata = {7'b0, lock_q};
      end
    endcase
  end

  // R1 / R2: ACPI codes never raise an SMI
  a_r1_acpi_on_no_smi: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data == ACPI_ON_CODE |=> acpi_on && smi_req == '0);
  a_r2_acpi_off_no_smi: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data == ACPI_OFF_CODE |=> acpi_off && smi_req == '0);
  // R3: gated by command-port enable
  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !en_q[APM_EN_BIT] |=> smi_req == '0);
  // R4: single-CPU delivery without broadcast
  a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !nego_q[BCAST_BIT] |=> $countones(smi_req) == 1);
  a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> smi_req == '0 && !acpi_on && !acpi_off);
  // R7: negotiation is one-shot
  a_r7_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |=> ok_q && $stable(nego_q));
  // R9: lock freezes itself and global enable
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q && $stable(en_q[0]));
endmodule

// File: tb/test_smi_dispatch.sv
module test_smi_dispatch;
  localparam int CLK_P = 10;
  localparam int NCPU  = 4;

  logic       clk = 0, rst_n = 0;
  logic       cmd_wr = 0, reg_wr = 0;
  logic [7:0] cmd_data = 0, reg_wdata = 0, reg_rdata;
  logic [1:0] cmd_cpu = 0;
  logic [4:0] reg_addr = 0;
  logic [NCPU-1:0] smi_req;
  logic       acpi_on, acpi_off;

  smi_dispatch #(.NUM_CPU(NCPU)) i_smi_dispatch (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .cmd_cpu(cmd_cpu),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smi_req(smi_req), .acpi_on(acpi_on), .acpi_off(acpi_off));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, fails = 0;
  bit done = 0;
  logic [63:0] m_host, m_req, m_nego;
  logic        m_ok, m_lock;
  logic [7:0]  m_en;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NCPU-1:0] exp_smi(logic [7:0] d, logic [1:0] c);
    if (d == 8'hE1 || d == 8'h1E || !m_en[5]) return '0;
    if (m_nego[0]) return '1;
    return NCPU'(1) << c;
  endfunction

  function automatic logic [7:0] exp_rd(logic [4:0] a);
    case (a)
      5'h10: return {7'b0, m_ok};
      5'h11: return m_en;
      5'h12: return {7'b0, m_lock};
      default: ;
    endcase
    if (a[4:3] == 2'b00) return m_host[{a[2:0], 3'b0} +: 8];
    if (a[4:3] == 2'b01) return m_req[{a[2:0], 3'b0} +: 8];
    if (a[4:3] == 2'b11) return m_nego[{a[2:0], 3'b0} +: 8];
    return 8'h00;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    m_host = 64'h1; m_req = 0; m_nego = 0; m_ok = 0; m_lock = 0; m_en = 0;
  endtask

  task automatic cmd(logic [7:0] d, logic [1:0] c);
    logic [NCPU-1:0] e;
    e = exp_smi(d, c);
    cmd_wr = 1; cmd_data = d; cmd_cpu = c;
    @(negedge clk); cmd_wr = 0;
    chk("R4 smi pulse", smi_req, e);
    chk("R1 acpi_on", acpi_on, d == 8'hE1);
    chk("R2 acpi_off", acpi_off, d == 8'h1E);
    @(negedge clk);
    chk("R4 pulse ends", {acpi_on, acpi_off, smi_req}, 0);
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    if (a[4:3] == 2'b01) m_req[{a[2:0], 3'b0} +: 8] = d;
    if (a == 5'h10 && !m_ok && (m_req & ~m_host) == 0) begin m_nego = m_req; m_ok = 1; end
    if (a == 5'h11) m_en = m_lock ? {d[7:1], m_en[0]} : d;
    if (a == 5'h12 && !m_lock) m_lock = d[0];
  endtask

  task automatic rd(string tag, logic [4:0] a);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp_rd(a));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R8 reset state
    for (int a = 0; a < 32; a++) rd("R8 reset read", 5'(a));
    // R10 read-only host/nego bytes
    wr(5'h00, 8'hFF); rd("R10 host ro", 5'h00);
    wr(5'h18, 8'hFF); rd("R10 nego ro", 5'h18);
    // R1 R2 R3
    cmd(8'hE1, 2); cmd(8'h1E, 1); cmd(8'h42, 3);
    wr(5'h11, 8'h20);
    cmd(8'h42, 3); cmd(8'hE1, 0);
    // R6 invalid request
    wr(5'h0D, 8'h80); wr(5'h10, 8'h01);
    rd("R6 ok stays 0", 5'h10); rd("R6 nego zero", 5'h18);
    // R5 valid request
    wr(5'h0D, 8'h00); wr(5'h08, 8'h01); wr(5'h10, 8'h00);
    rd("R5 ok set", 5'h10); rd("R5 nego latched", 5'h18);
    cmd(8'h55, 1);
    // R7 sticky
    wr(5'h08, 8'h00); wr(5'h10, 8'h01);
    rd("R7 ok held", 5'h10); rd("R7 nego held", 5'h18);
    cmd(8'h07, 2);
    // R9 lock
    wr(5'h11, 8'h21); wr(5'h12, 8'h01);
    wr(5'h11, 8'h40); rd("R9 en bit0 frozen", 5'h11);
    wr(5'h12, 8'h00); rd("R9 lock sticky", 5'h12);
    // R8 reset clears negotiation
    do_reset();
    rd("R8 ok cleared", 5'h10); rd("R8 nego cleared", 5'h18);
    rd("R8 lock cleared", 5'h12); rd("R8 host", 5'h00);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        logic [7:0] d;
        d = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) != 0) ? 8'hE1 : 8'h1E) : 8'($urandom);
        cmd(d, 2'($urandom));
      end else if (op < 8) begin
        logic [4:0] a;
        logic [7:0] d;
        a = 5'($urandom);
        if ($urandom_range(0, 2) == 0) a = 5'h10 + 5'($urandom_range(0, 2));
        d = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 1)) : 8'($urandom);
        if (a == 5'h11 && $urandom_range(0, 1) != 0) d = d | 8'h20;
        wr(a, d);
      end else if (op == 8) begin
        rd("R10 random read", 5'($urandom));
      end else if ($urandom_range(0, 20) == 0) begin
        do_reset();
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule